// File: doc/BRIEF.md
# Fetch-Tracked Single-Screen Nametable Selector

This block steers the console's single-screen nametable line from the character pattern fetches of the picture processor, and not from a fixed mirroring register. Each valid picture-processor address below $2000 falls in one of eight 1 KB pattern regions. The block records the most recent such region. It drives the nametable select from a table that holds one select bit per region.

Addresses at $2000 and above are nametable and palette traffic. They leave the recorded region alone, so the screen chosen by the last pattern fetch stays in force while those bytes are read. The per-region bits are loaded by the character-bank register front end. A write to one of the two 2 KB bank registers sets a pair of entries. A write to one of the four 1 KB bank registers sets a single entry. The parameter `SEL_BIT` picks which data bit carries the select: 7 for the direct-mapped variant and 5 for the indexed variant.

The output is registered. It reflects the table and the region as they stand after each clock edge. A table write that hits the region now being tracked therefore shows on the output one cycle later, with no further fetch needed.

Top module: `chr_region_nt_select`

## Requirements
- R1: After reset `nt_sel` is 0, all eight table entries are 0 and the tracked region is 0.
- R2: When `ppu_valid` is 1 and `ppu_addr` < 14'h2000, the tracked region becomes `ppu_addr[12:10]`. One clock later `nt_sel` equals that region's table entry.
- R3: A valid address of 14'h2000 or above leaves the tracked region unchanged, and `nt_sel` holds its value.
- R4: While `ppu_valid` is 0 the address is ignored, and `nt_sel` holds its value when there is no table write.
- R5: A write with `tbl_idx` = 0 sets entries 0 and 1. A write with `tbl_idx` = 1 sets entries 2 and 3.
- R6: A write with `tbl_idx` = k, where k is 2 to 5, sets entry k+2 only.
- R7: The value written is `tbl_data[SEL_BIT]`. The other data bits have no effect. The default `SEL_BIT` is 7.
- R8: Writes with `tbl_idx` 6 or 7 change no entry.
- R9: A write to an entry of the currently tracked region shows on `nt_sel` one clock later, without another fetch.
- R10: When a fetch and a table write occur in the same cycle, the next `nt_sel` is the updated entry of the newly fetched region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Picture-processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ppu_addr | input | 14 | Picture-processor address |
| ppu_valid | input | 1 | Address strobe, 1 when `ppu_addr` is a real access |
| tbl_we | input | 1 | Bank-register write strobe |
| tbl_idx | input | 3 | Character bank register number |
| tbl_data | input | 8 | Written bank value |
| nt_sel | output | 1 | Single-screen nametable select, 0 or 1 |

## Verification
The bench sweeps the whole 14-bit address space. A design that compared against the wrong boundary, or took the region from the wrong bits, would switch screens during nametable reads or follow the wrong table entry. Every register number is written with data that sets and then clears only the select bit, and with data that has every other bit set. This exposes a wrong pair mapping, a spill into neighbouring entries from numbers 6 and 7, or the use of a wrong data bit. Writes that hit the tracked region without a fetch, and writes that land together with a fetch, catch a design that updates the output only on a fetch or reads a stale table.

// File: rtl/chr_region_nt_select.sv
module chr_region_nt_select #(
  parameter int SEL_BIT = 7,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ppu_addr,
  input  logic              ppu_valid,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              nt_sel
);

  localparam int REGIONS = 8;
  localparam int RGN_W   = $clog2(REGIONS);
  localparam int RGN_LO  = ADDR_W - 1 - RGN_W;
  localparam int PAIRS   = 2;

  logic [REGIONS-1:0] sel_q, sel_d;
  logic [RGN_W-1:0]   rgn_q, rgn_d;
  logic               nt_q;
  logic               fetch;
  logic               wbit;

  wire unused_bits = ^{tbl_data, ppu_addr[RGN_LO-1:0]};

  assign fetch = ppu_valid && !ppu_addr[ADDR_W-1];
  assign wbit  = tbl_data[SEL_BIT];
  assign rgn_d = fetch ? ppu_addr[ADDR_W-2:RGN_LO] : rgn_q;

  always_comb begin
    sel_d = sel_q;
    if (tbl_we) begin
      for (int e = 0; e < REGIONS; e++) begin
        if (e < 2*PAIRS) begin
          if (int'(tbl_idx) == e/2) sel_d[e] = wbit;
        end else begin
          if (int'(tbl_idx) == e - PAIRS) sel_d[e] = wbit;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      rgn_q <= '0;
      nt_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rgn_q <= rgn_d;
      nt_q  <= sel_d[rgn_d];
    end
  end

  assign nt_sel = nt_q;

  // R3
  high_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_valid && ppu_addr[ADDR_W-1] && !tbl_we) |=> $stable(nt_sel));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ppu_valid && !tbl_we) |=> $stable(nt_sel));

  // R8
  spare_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_idx >= 3'd6 && !fetch) |=> $stable(nt_sel));

  // R9
  live_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !fetch && tbl_idx == 3'd2 && rgn_q == 3'd4) |=> (nt_sel == $past(tbl_data[SEL_BIT])));

  // R10
  joint_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && fetch && tbl_idx == 3'd5 && ppu_addr[ADDR_W-2:RGN_LO] == 3'd7) |=> (nt_sel == $past(tbl_data[SEL_BIT])));

endmodule

// File: tb/chr_region_nt_select_bench.sv
module chr_region_nt_select_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_valid = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [7:0]  tbl_data = '0;
  logic        nt_sel;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_tbl = '0;
  logic [2:0] m_rgn = '0;
  logic       m_out = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  chr_region_nt_select u_chr_region_nt_select (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_valid(ppu_valid),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data), .nt_sel(nt_sel)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (nt_sel !== exp) begin
      fails++;
      $display("FAIL %s: nt_sel=%b expected=%b", tag, nt_sel, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic we, input logic [2:0] idx,
                     input logic [7:0] d, input logic v, input logic [13:0] a);
    @(negedge clk);
    tbl_we = we; tbl_idx = idx; tbl_data = d; ppu_valid = v; ppu_addr = a;
    if (we) begin
      case (idx)
        3'd0: begin m_tbl[0] = d[7]; m_tbl[1] = d[7]; end
        3'd1: begin m_tbl[2] = d[7]; m_tbl[3] = d[7]; end
        3'd2, 3'd3, 3'd4, 3'd5: m_tbl[idx + 3'd2] = d[7];
        default: ;
      endcase
    end
    if (v && a < 14'h2000) m_rgn = a[12:10];
    m_out = m_tbl[m_rgn];
    @(negedge clk);
    tbl_we = 1'b0; ppu_valid = 1'b0;
    check(tag, m_out);
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    for (int r = 0; r < 8; r++) cyc("R1", 0, 0, 0, 1, 14'(r * 1024 + 5));

    // R5 R6 R7 R8: each register, select bit set and cleared, other bits noise
    for (int k = 0; k < 8; k++) begin
      cyc("R7", 1, 3'(k), 8'h80, 0, 0);
      for (int r = 0; r < 8; r++) cyc(k < 2 ? "R5" : (k < 6 ? "R6" : "R8"), 0, 0, 0, 1, 14'(r * 1024));
      cyc("R7", 1, 3'(k), 8'h7F, 0, 0);
      for (int r = 0; r < 8; r++) cyc("R7", 0, 0, 0, 1, 14'(r * 1024 + 3));
    end
    cyc("R7", 1, 3'd6, 8'hFF, 0, 0);
    cyc("R8", 1, 3'd7, 8'hFF, 0, 0);
    for (int r = 0; r < 8; r++) cyc("R8", 0, 0, 0, 1, 14'(r * 1024));

    // alternating table, full address sweep
    cyc("R5", 1, 0, 8'h80, 0, 0);
    cyc("R5", 1, 1, 8'h00, 0, 0);
    cyc("R6", 1, 2, 8'hFF, 0, 0);
    cyc("R6", 1, 3, 8'h00, 0, 0);
    cyc("R6", 1, 4, 8'h80, 0, 0);
    cyc("R6", 1, 5, 8'h20, 0, 0);
    for (int a = 0; a < 16384; a += 8)
      cyc(a < 8192 ? "R2" : "R3", 0, 0, 0, 1, 14'(a));

    // R4: strobe low ignores low addresses
    cyc("R2", 0, 0, 0, 1, 14'h0000);
    for (int a = 0; a < 8192; a += 512) cyc("R4", 0, 0, 0, 0, 14'(a + 1024));

    // R9: live writes to the tracked region
    cyc("R2", 0, 0, 0, 1, 14'h1000);
    cyc("R9", 1, 2, 8'h00, 0, 0);
    cyc("R9", 1, 2, 8'h80, 0, 0);
    cyc("R9", 1, 3, 8'h00, 0, 0);
    cyc("R2", 0, 0, 0, 1, 14'h0400);
    cyc("R9", 1, 0, 8'h7F, 0, 0);
    cyc("R9", 1, 0, 8'hFF, 1, 14'h2400);

    // R10: write and fetch together
    cyc("R10", 1, 5, 8'h80, 1, 14'h1C00);
    cyc("R10", 1, 5, 8'h00, 1, 14'h1FFF);
    cyc("R10", 1, 1, 8'h80, 1, 14'h0800);
    cyc("R10", 1, 1, 8'h00, 1, 14'h1000);

    // reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_tbl = '0; m_rgn = '0;
    check("R1", 1'b0);
    for (int r = 0; r < 8; r++) cyc("R1", 0, 0, 0, 1, 14'(r * 1024));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule